// File: doc/BRIEF.md
# Bidirectional Latched Bus Transceiver

This block sits between two 8-bit ports, A and B, and can move data in either direction. Each direction owns a separate storage register. A transfer from A to B captures the A input into the A-to-B store, and the B port presents that store. A transfer from B to A works the same way through its own store, and the A port presents it. Neither store ever touches the other.

Each direction has three active-low controls: an enable, a latch enable and an output enable. The enable gates the other two. When the enable and the latch enable are both low, the store follows its input port. When either of them is high, the store holds its value. When the enable and the output enable are both low, the far port's drive flag is raised. Each port is modelled as an input vector, an output vector and a drive-enable flag, not as an inout.

The storage is a clocked equivalent of a latch. A transparent store reloads on every rising edge of a sampling clock, so the value it keeps is the one sampled at the last edge where it was still transparent. If both directions are transparent and both ports are driven at once, the block raises an error flag and does not form a loop.

Top module: `bilatch_xcvr`

## Requirements
- R1: While `rst_n` is low, both stores are cleared to zero at the clock edge, both drive flags are low and `conflict` is low, whatever the controls are.
- R2: When `ab_en_n` and `ab_le_n` are both low at a rising edge, the A-to-B store loads `a_in`. `b_out` shows the new value after that edge, and it reloads at every such edge.
- R3: When `ab_en_n` is low and `ab_le_n` is high at an edge, the A-to-B store keeps its value, even if `a_in` changes. `b_out` always presents the store, whether or not it is driven.
- R4: `b_drive` is high exactly when `rst_n` is high and both `ab_en_n` and `ab_oe_n` are low. While it is high, `b_out` carries the A-to-B store.
- R5: When `ab_en_n` is high, the A-to-B store does not load and `b_drive` is low, whatever `ab_le_n` and `ab_oe_n` are.
- R6: The B-to-A direction follows R2 to R5 with `ba_en_n`, `ba_le_n` and `ba_oe_n`, loading from `b_in` and presenting on `a_out` and `a_drive`.
- R7: `conflict` is high exactly when `rst_n` is high and all six direction controls are low, that is, both stores are transparent and both ports are driven.
- R8: Loading or holding one direction never changes the other direction's store.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock; stores update on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| ab_en_n | input | 1 | A-to-B enable, active low |
| ab_le_n | input | 1 | A-to-B latch enable, active low |
| ab_oe_n | input | 1 | A-to-B output enable, active low |
| ba_en_n | input | 1 | B-to-A enable, active low |
| ba_le_n | input | 1 | B-to-A latch enable, active low |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| a_in | input | 8 | Value seen on port A |
| a_out | output | 8 | B-to-A store contents, presented on port A |
| a_drive | output | 1 | Port A is driven when high |
| b_in | input | 8 | Value seen on port B |
| b_out | output | 8 | A-to-B store contents, presented on port B |
| b_drive | output | 1 | Port B is driven when high |
| conflict | output | 1 | Both directions transparent and both ports driven |

## Verification
The hardest case to reach from the ports is a store that must hold while its input keeps changing. This happens just after the latch enable rises, and again when a high direction enable masks a low latch enable. The stimulus first loads a known value. It then raises the latch enable, or the direction enable, and moves the input to a new value in the same step. It confirms through the always-visible output vector that the old value stayed. The conflict case is reached by dropping all six controls together after both stores hold distinct values. That step also checks that each store loads its own port and only its own port.

// File: rtl/bilatch_pkg.sv
// Package: shared types and constants for the latched bus transceiver.
// Assumes two directions, indexed by the constants below.
package bilatch_pkg;
    localparam int NUM_DIR = 2;
    localparam int DIR_AB  = 0;
    localparam int DIR_BA  = 1;

    // Active-low control triple for one direction.
    typedef struct packed {
        logic en_n;
        logic le_n;
        logic oe_n;
    } dir_ctl_t;
endpackage

// File: rtl/bilatch_lane.sv
// Module: one direction of the transceiver.
// Holds a clocked store that reloads from its input at every edge while
// the direction is transparent, and holds otherwise. It also produces the
// far port's drive flag. Assumes a synchronous active-low reset.
module bilatch_lane
    import bilatch_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  dir_ctl_t     ctl,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         drive,
    output logic         transp
);
    logic [W-1:0] store_q;
    logic         open_w;
    logic         emit_w;

    // Decode the gated latch and output conditions.
    always_comb begin
        open_w = ~ctl.en_n & ~ctl.le_n;
        emit_w = ~ctl.en_n & ~ctl.oe_n;
    end

    // Store update: clear on reset, follow input while transparent.
    always_ff @(posedge clk) begin
        if (!rst_n)
            store_q <= '0;
        else if (open_w)
            store_q <= din;
    end

    // Drive outputs and transparency flag.
    always_comb begin
        dout   = store_q;
        drive  = rst_n & emit_w;
        transp = rst_n & open_w;
    end

    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl.en_n && !ctl.le_n) |=> (dout == $past(din)))
        else $error("lane did not load while transparent");

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl.en_n && ctl.le_n) |=> $stable(dout))
        else $error("lane changed while holding");

    p_en_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.en_n |=> $stable(dout))
        else $error("lane loaded while disabled");

    p_no_drive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.en_n |-> !drive)
        else $error("lane drove while disabled");
endmodule

// File: rtl/bilatch_clash.sv
// Module: flags the state in which both directions are transparent and
// both ports are driven. Assumes its inputs are already qualified by reset.
module bilatch_clash (
    input  logic ab_transp,
    input  logic ba_transp,
    input  logic a_drv,
    input  logic b_drv,
    output logic clash
);
    // Combine the four conditions into one error flag.
    always_comb begin
        clash = ab_transp & ba_transp & a_drv & b_drv;
    end
endmodule

// File: rtl/bilatch_xcvr.sv
// Module: top of the bidirectional latched transceiver.
// Instantiates one lane per direction and the clash detector. Port A feeds
// the A-to-B lane, which presents on port B, and the reverse. Assumes
// the controls are sampled on the rising edge of clk.
module bilatch_xcvr
    import bilatch_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ab_en_n,
    input  logic         ab_le_n,
    input  logic         ab_oe_n,
    input  logic         ba_en_n,
    input  logic         ba_le_n,
    input  logic         ba_oe_n,
    input  logic [W-1:0] a_in,
    output logic [W-1:0] a_out,
    output logic         a_drive,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] b_out,
    output logic         b_drive,
    output logic         conflict
);
    dir_ctl_t     ctl    [NUM_DIR];
    logic [W-1:0] din    [NUM_DIR];
    logic [W-1:0] dout   [NUM_DIR];
    logic         drive  [NUM_DIR];
    logic         transp [NUM_DIR];

    // Route the ports onto the per-direction arrays.
    always_comb begin
        ctl[DIR_AB] = '{en_n: ab_en_n, le_n: ab_le_n, oe_n: ab_oe_n};
        ctl[DIR_BA] = '{en_n: ba_en_n, le_n: ba_le_n, oe_n: ba_oe_n};
        din[DIR_AB] = a_in;
        din[DIR_BA] = b_in;
    end

    genvar g;
    generate
        for (g = 0; g < NUM_DIR; g++) begin : g_lane
            bilatch_lane #(.W(W)) u_lane (
                .clk    (clk),
                .rst_n  (rst_n),
                .ctl    (ctl[g]),
                .din    (din[g]),
                .dout   (dout[g]),
                .drive  (drive[g]),
                .transp (transp[g])
            );
        end
    endgenerate

    bilatch_clash u_clash (
        .ab_transp (transp[DIR_AB]),
        .ba_transp (transp[DIR_BA]),
        .a_drv     (drive[DIR_BA]),
        .b_drv     (drive[DIR_AB]),
        .clash     (conflict)
    );

    // Present each lane on the opposite port.
    always_comb begin
        b_out   = dout[DIR_AB];
        b_drive = drive[DIR_AB];
        a_out   = dout[DIR_BA];
        a_drive = drive[DIR_BA];
    end

    p_clash_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ab_en_n && !ab_le_n && !ab_oe_n && !ba_en_n && !ba_le_n && !ba_oe_n)
        |-> conflict)
        else $error("conflict not flagged");

    p_no_false_clash_r7: assert property (@(posedge clk) disable iff (!rst_n)
        conflict |-> (a_drive && b_drive))
        else $error("conflict without both ports driven");

    p_keep_ba_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ba_en_n |=> $stable(a_out))
        else $error("B-to-A store moved while its direction was off");

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |-> (!a_drive && !b_drive && !conflict))
        else $error("port driven during reset");
endmodule

// File: tb/bilatch_xcvr_tb.sv
module bilatch_xcvr_tb;
    localparam int W = 8;

    typedef struct {
        logic [W-1:0] bo;
        logic [W-1:0] ao;
        logic         bd;
        logic         ad;
        logic         cf;
        string        tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ab_en_n = 1'b1, ab_le_n = 1'b1, ab_oe_n = 1'b1;
    logic         ba_en_n = 1'b1, ba_le_n = 1'b1, ba_oe_n = 1'b1;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic [W-1:0] a_out, b_out;
    logic         a_drive, b_drive, conflict;

    exp_t         sb[$];
    logic [W-1:0] m_ab = '0, m_ba = '0;
    int           total = 0;
    int           bad = 0;
    bit           done = 0;

    always #10 clk = ~clk;

    bilatch_xcvr #(.W(W)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .ab_en_n(ab_en_n), .ab_le_n(ab_le_n), .ab_oe_n(ab_oe_n),
        .ba_en_n(ba_en_n), .ba_le_n(ba_le_n), .ba_oe_n(ba_oe_n),
        .a_in(a_in), .a_out(a_out), .a_drive(a_drive),
        .b_in(b_in), .b_out(b_out), .b_drive(b_drive),
        .conflict(conflict)
    );

    // Driver: ctl = {ab_en_n, ab_le_n, ab_oe_n, ba_en_n, ba_le_n, ba_oe_n}
    task automatic step(input logic rst, input logic [5:0] ctl,
                        input logic [W-1:0] av, input logic [W-1:0] bv,
                        input string tag);
        exp_t e;
        @(negedge clk);
        rst_n = rst;
        {ab_en_n, ab_le_n, ab_oe_n, ba_en_n, ba_le_n, ba_oe_n} = ctl;
        a_in = av;
        b_in = bv;
        if (!rst) begin
            m_ab = '0;
            m_ba = '0;
        end else begin
            if (!ctl[5] && !ctl[4]) m_ab = av;
            if (!ctl[2] && !ctl[1]) m_ba = bv;
        end
        e.bo  = m_ab;
        e.ao  = m_ba;
        e.bd  = rst & !ctl[5] & !ctl[3];
        e.ad  = rst & !ctl[2] & !ctl[0];
        e.cf  = rst & (ctl == 6'b000000);
        e.tag = tag;
        sb.push_back(e);
    endtask

    // Monitor: compare a quarter period after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                total++;
                if (b_out !== e.bo || a_out !== e.ao || b_drive !== e.bd ||
                    a_drive !== e.ad || conflict !== e.cf) begin
                    bad++;
                    $display("FAIL %s act b_out=%h a_out=%h bd=%b ad=%b cf=%b exp b_out=%h a_out=%h bd=%b ad=%b cf=%b",
                             e.tag, b_out, a_out, b_drive, a_drive, conflict,
                             e.bo, e.ao, e.bd, e.ad, e.cf);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        #(20 * 5000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1: reset with all controls low must not drive or flag
        step(1'b0, 6'b000000, 8'hAA, 8'h55, "R1 reset controls low");
        step(1'b0, 6'b111111, 8'h00, 8'h00, "R1 reset idle");
        // R2: transparent A-to-B follows a_in each edge
        step(1'b1, 6'b001111, 8'h5A, 8'h00, "R2 load 5A");
        step(1'b1, 6'b001111, 8'h3C, 8'h00, "R2 reload 3C");
        for (int i = 0; i < 4; i++)
            step(1'b1, 6'b001111, 8'(8'h11 * (i + 1)), 8'h00, "R2 sweep");
        step(1'b1, 6'b001111, 8'h3C, 8'h00, "R2 reload 3C again");
        // R3: latch enable high holds despite new input
        step(1'b1, 6'b011111, 8'hFF, 8'h00, "R3 hold after le rise");
        // R4: output enable low drives B with held value
        step(1'b1, 6'b010111, 8'h81, 8'h00, "R4 drive held");
        // R5: enable high blocks load and drive
        step(1'b1, 6'b100111, 8'h11, 8'h00, "R5 enable high masks");
        step(1'b1, 6'b110111, 8'h22, 8'h00, "R5 enable high idle");
        // R6 and R8: B-to-A load and drive, A-to-B untouched
        step(1'b1, 6'b111000, 8'h00, 8'hA5, "R6 R8 ba load drive");
        step(1'b1, 6'b111010, 8'h00, 8'h0F, "R6 ba hold");
        step(1'b1, 6'b111100, 8'h00, 8'hF0, "R6 ba enable high");
        // R8: A-to-B load leaves B-to-A store alone
        step(1'b1, 6'b001111, 8'h77, 8'h99, "R8 ab load only");
        // R7: all low flags conflict, both load
        step(1'b1, 6'b000000, 8'hC3, 8'h3C, "R7 conflict");
        step(1'b1, 6'b000001, 8'hC3, 8'h3C, "R7 no conflict one oe high");
        step(1'b1, 6'b111111, 8'h00, 8'h00, "R3 idle hold");
        // R1: reset again clears both stores
        step(1'b0, 6'b000000, 8'h12, 8'h34, "R1 reset clears");
        step(1'b1, 6'b011011, 8'h12, 8'h34, "R1 cleared after reset");
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule